// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the raster timing of one display output: horizontal sync, vertical sync, data-enable, a one-cycle vertical-blank pulse for software events, and the coordinate of the pixel being shown. It has one counter for each axis. Each counter steps through four phases in a fixed order: sync, back porch, active, front porch. The horizontal counter advances on every pixel clock. The vertical counter advances once, at the last pixel of each line.

Software programs the block through a simple write port. There are four length registers per axis, one for each phase, and each holds its length minus one. A polarity register sets the active level of each output. A command register starts and stops scanning. While scanning is stopped, every output sits at its inactive level and both counters wait at the start of the sync phase. Pixel data, clock generation and memory access belong to other blocks.

Top module: `raster_timing_gen`

## Requirements
- R1: After a synchronous active-low reset, hsync_o, vsync_o, de_o, vblank_o, px_x, px_y and data_inv_o all read 0. Reset leaves the polarity register at 4'hF, all length registers at 0 and scanning stopped.
- R2: While scanning, each line runs sync, back porch, active and front porch, lasting (H_SYNC+1), (H_BACK+1), (H_ACT+1) and (H_FRONT+1) cycles respectively. hsync is asserted in the sync phase only. The length registers sit at addresses 2 (sync), 3 (back), 4 (active) and 5 (front).
- R3: de_o is asserted only when both axes are in their active phase. During the active phase px_x counts 0, 1, … H_ACT, one step per cycle. px_x reads 0 whenever de is not in the horizontal active phase while scanning.
- R4: The vertical axis uses the same phase order, measured in lines, with lengths (V_SYNC+1), (V_BACK+1), (V_ACT+1) and (V_FRONT+1) at addresses 6, 7, 8 and 9. vsync is asserted during the vertical sync lines. px_y gives the active line index 0…V_ACT during active lines and 0 on all other lines.
- R5: Polarity register (address 1): bit0 is hsync, bit1 is vsync, bit2 is data-enable, bit3 is data. A set bit makes that output active-high and a clear bit makes it active-low. data_inv_o always reads the inverse of bit3.
- R6: Writing a value with bit0 = 1 to the command register (address 0) starts scanning, and the first cycle after the write is the first sync cycle of line 0. Writing bit0 = 0 drives all outputs inactive from the next cycle onward. A later start begins again from the first sync cycle.
- R7: vblank_o is high for exactly one cycle: the first cycle of the first line after the last active line, which is the first front-porch line.
- R8: Writes to addresses 10 to 15 change neither the timing nor the output levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 16 | Register write data |
| hsync_o | output | 1 | Horizontal sync, level set by polarity bit0 |
| vsync_o | output | 1 | Vertical sync, level set by polarity bit1 |
| de_o | output | 1 | Data enable, level set by polarity bit2 |
| data_inv_o | output | 1 | High when pixel data is to be sent active-low |
| vblank_o | output | 1 | One-cycle pulse at the start of vertical blanking |
| px_x | output | 12 | Active pixel column |
| px_y | output | 12 | Active line index |

## Verification
The main function is tried with three timing sets:
- A small asymmetric set, in which every phase has a different length, so that a swapped or off-by-one phase shows up at once.
- An all-minimum set, in which every phase is one cycle long, so that wrap and last-count decisions coincide.
- A larger set, which exercises multi-bit counts.

Each set runs for two or more full frames. This separates errors in the frame wrap from errors within a single line. Polarity patterns 0101 and 1010 separate crossed polarity bits from a global inversion. A stop in mid-line followed by a restart shows whether the counters really return to the first sync cycle. Writes to unmapped addresses are then followed by a full frame, to confirm that nothing moved.

// File: rtl/rtg_pkg.sv
// Shared types and constants for the raster timing generator.
// Assumes a single clock domain; the address map is fixed here.
package rtg_pkg;
    typedef enum logic [1:0] {
        PH_SYNC  = 2'd0,
        PH_BACK  = 2'd1,
        PH_ACT   = 2'd2,
        PH_FRONT = 2'd3
    } phase_t;

    localparam int ADDR_CMD  = 0;
    localparam int ADDR_POL  = 1;
    localparam int ADDR_TIM0 = 2;
    localparam int NUM_PHASE = 4;
    localparam int NUM_TIM   = 2 * NUM_PHASE;

    localparam int POL_HS  = 0;
    localparam int POL_VS  = 1;
    localparam int POL_DE  = 2;
    localparam int POL_DAT = 3;
    localparam int POL_W   = 4;
endpackage

// File: rtl/rtg_regs.sv
// Register store: command, polarity and the eight phase lengths.
// Write-only port; unmapped addresses are ignored. Assumes DW >= CW.
module rtg_regs #(
    parameter int AW = 4,
    parameter int DW = 16,
    parameter int CW = 12
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 cfg_we,
    input  logic [AW-1:0]                        cfg_addr,
    input  logic [DW-1:0]                        cfg_wdata,
    output logic                                 run_q,
    output logic [rtg_pkg::POL_W-1:0]            pol_q,
    output logic [rtg_pkg::NUM_TIM-1:0][CW-1:0]  tim_q
);
    import rtg_pkg::*;

    localparam logic [AW-1:0] A_CMD = AW'(ADDR_CMD);
    localparam logic [AW-1:0] A_POL = AW'(ADDR_POL);

    // Command and polarity registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            pol_q <= '1;
        end else if (cfg_we) begin
            if (cfg_addr == A_CMD) run_q <= cfg_wdata[0];
            if (cfg_addr == A_POL) pol_q <= cfg_wdata[POL_W-1:0];
        end
    end

    // One length register per phase per axis.
    for (genvar i = 0; i < NUM_TIM; i++) begin : g_tim
        localparam logic [AW-1:0] A_TIM = AW'(ADDR_TIM0 + i);
        always_ff @(posedge clk) begin
            if (!rst_n)
                tim_q[i] <= '0;
            else if (cfg_we && cfg_addr == A_TIM)
                tim_q[i] <= cfg_wdata[CW-1:0];
        end
    end
endmodule

// File: rtl/rtg_axis.sv
// One axis counter: walks sync, back, active, front phases, each lasting
// its programmed length plus one steps. Clear returns it to sync, count 0.
// Assumes lengths stay constant while stepping.
module rtg_axis #(
    parameter int CW = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            step,
    input  logic [CW-1:0]   len_sync,
    input  logic [CW-1:0]   len_back,
    input  logic [CW-1:0]   len_act,
    input  logic [CW-1:0]   len_front,
    output rtg_pkg::phase_t phase,
    output logic [CW-1:0]   cnt,
    output logic            at_end
);
    import rtg_pkg::*;

    logic [CW-1:0] cur_len;
    logic          last;

    // Select the length of the current phase.
    always_comb begin
        case (phase)
            PH_SYNC:  cur_len = len_sync;
            PH_BACK:  cur_len = len_back;
            PH_ACT:   cur_len = len_act;
            default:  cur_len = len_front;
        endcase
        last   = (cnt == cur_len);
        at_end = last && (phase == PH_FRONT);
    end

    // Advance count and phase.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            phase <= PH_SYNC;
            cnt   <= '0;
        end else if (step) begin
            if (last) begin
                phase <= phase_t'(phase + 2'd1);
                cnt   <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/rtg_outs.sv
// Output forming: raw phase decodes gated by run, then polarity applied.
// Purely combinational from registered state; no input feeds through.
module rtg_outs #(
    parameter int CW = 12
) (
    input  logic                       run,
    input  logic [rtg_pkg::POL_W-1:0]  pol,
    input  rtg_pkg::phase_t            h_phase,
    input  logic [CW-1:0]              h_cnt,
    input  rtg_pkg::phase_t            v_phase,
    input  logic [CW-1:0]              v_cnt,
    output logic                       hsync_o,
    output logic                       vsync_o,
    output logic                       de_o,
    output logic                       data_inv_o,
    output logic                       vblank_o,
    output logic [CW-1:0]              px_x,
    output logic [CW-1:0]              px_y
);
    import rtg_pkg::*;

    logic hs_raw, vs_raw, h_act, v_act, de_raw;

    // Decode phases into active-high raw strobes and coordinates.
    always_comb begin
        hs_raw   = run && (h_phase == PH_SYNC);
        vs_raw   = run && (v_phase == PH_SYNC);
        h_act    = run && (h_phase == PH_ACT);
        v_act    = run && (v_phase == PH_ACT);
        de_raw   = h_act && v_act;
        vblank_o = run && (v_phase == PH_FRONT) && (v_cnt == '0)
                   && (h_phase == PH_SYNC) && (h_cnt == '0);
        px_x     = h_act ? h_cnt : '0;
        px_y     = v_act ? v_cnt : '0;
    end

    // Apply polarity: a set bit keeps the raw level, a clear bit inverts.
    always_comb begin
        hsync_o    = pol[POL_HS] ? hs_raw : !hs_raw;
        vsync_o    = pol[POL_VS] ? vs_raw : !vs_raw;
        de_o       = pol[POL_DE] ? de_raw : !de_raw;
        data_inv_o = !pol[POL_DAT];
    end
endmodule

// File: rtl/raster_timing_gen.sv
// Top of the raster timing generator: register store, two axis counters
// and output forming. The vertical axis steps at the end of each line.
module raster_timing_gen #(
    parameter int AW = 4,
    parameter int DW = 16,
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [AW-1:0] cfg_addr,
    input  logic [DW-1:0] cfg_wdata,
    output logic          hsync_o,
    output logic          vsync_o,
    output logic          de_o,
    output logic          data_inv_o,
    output logic          vblank_o,
    output logic [CW-1:0] px_x,
    output logic [CW-1:0] px_y
);
    import rtg_pkg::*;

    logic                          run_q;
    logic [POL_W-1:0]              pol_q;
    logic [NUM_TIM-1:0][CW-1:0]    tim_q;
    phase_t                        h_phase, v_phase;
    logic [CW-1:0]                 h_cnt, v_cnt;
    logic                          h_end, v_end;

    rtg_regs #(.AW(AW), .DW(DW), .CW(CW)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .run_q(run_q), .pol_q(pol_q), .tim_q(tim_q)
    );

    rtg_axis #(.CW(CW)) u_hax (
        .clk(clk), .rst_n(rst_n), .clear(!run_q), .step(run_q),
        .len_sync(tim_q[0]), .len_back(tim_q[1]),
        .len_act(tim_q[2]), .len_front(tim_q[3]),
        .phase(h_phase), .cnt(h_cnt), .at_end(h_end)
    );

    rtg_axis #(.CW(CW)) u_vax (
        .clk(clk), .rst_n(rst_n), .clear(!run_q), .step(run_q && h_end),
        .len_sync(tim_q[4]), .len_back(tim_q[5]),
        .len_act(tim_q[6]), .len_front(tim_q[7]),
        .phase(v_phase), .cnt(v_cnt), .at_end(v_end)
    );

    rtg_outs #(.CW(CW)) u_outs (
        .run(run_q), .pol(pol_q),
        .h_phase(h_phase), .h_cnt(h_cnt), .v_phase(v_phase), .v_cnt(v_cnt),
        .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
        .data_inv_o(data_inv_o), .vblank_o(vblank_o),
        .px_x(px_x), .px_y(px_y)
    );

    logic unused_v_end;
    assign unused_v_end = v_end;
endmodule

// File: rtl/rtg_checker.sv
// Assertion checker for raster_timing_gen, attached by bind below.
module rtg_checker #(
    parameter int CW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          run_q,
    input logic [3:0]    pol_q,
    input logic          hsync_o,
    input logic          vsync_o,
    input logic          de_o,
    input logic          vblank_o,
    input logic [CW-1:0] px_x
);
    logic hs_act, vs_act, de_act;
    assign hs_act = (hsync_o == pol_q[0]);
    assign vs_act = (vsync_o == pol_q[1]);
    assign de_act = (de_o == pol_q[2]);

    // R7: the blank pulse never lasts two cycles.
    p_vblank_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        vblank_o |=> !vblank_o);

    // R7: the blank pulse never coincides with displayed data.
    p_vblank_no_de_r7: assert property (@(posedge clk) disable iff (!rst_n)
        vblank_o |-> !de_act);

    // R2: sync and data-enable are never active together.
    p_de_hs_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        de_act |-> !hs_act);

    // R3: column increments by one across consecutive enabled cycles.
    p_x_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (de_act && $past(de_act)) |-> (px_x == $past(px_x) + 1'b1));

    // R6: stopped means every output is inactive.
    p_stopped_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |-> (!hs_act && !vs_act && !de_act && !vblank_o));
endmodule

bind raster_timing_gen rtg_checker #(.CW(CW)) u_rtg_chk (
    .clk(clk), .rst_n(rst_n), .run_q(run_q), .pol_q(pol_q),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
    .vblank_o(vblank_o), .px_x(px_x)
);

// File: tb/raster_timing_gen_bench.sv
`timescale 1ns/1ps
module raster_timing_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        hsync_o, vsync_o, de_o, data_inv_o, vblank_o;
    logic [11:0] px_x, px_y;

    raster_timing_gen u_raster_timing_gen (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .hsync_o(hsync_o), .vsync_o(vsync_o),
        .de_o(de_o), .data_inv_o(data_inv_o), .vblank_o(vblank_o),
        .px_x(px_x), .px_y(px_y)
    );

    always #2 clk = ~clk;

    int    total = 0;
    int    bad = 0;
    bit    done = 0;
    bit    chk_en = 0;
    string ptag = "R2";

    // Behavioural reference state.
    int m_run = 0;
    int m_pol = 15;
    int ml[8] = '{default: 0};
    int hc = 0;
    int vc = 0;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model: advance with old settings, then take any write.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_pol = 15; hc = 0; vc = 0;
            for (int i = 0; i < 8; i++) ml[i] = 0;
        end else begin
            int htot, vtot;
            htot = ml[0] + ml[1] + ml[2] + ml[3] + 4;
            vtot = ml[4] + ml[5] + ml[6] + ml[7] + 4;
            if (m_run != 0) begin
                if (hc == htot - 1) begin
                    hc = 0;
                    vc = (vc == vtot - 1) ? 0 : vc + 1;
                end else hc = hc + 1;
            end else begin
                hc = 0; vc = 0;
            end
            if (cfg_we) begin
                if (cfg_addr == 0) m_run = int'(cfg_wdata[0]);
                else if (cfg_addr == 1) m_pol = int'(cfg_wdata[3:0]);
                else if (cfg_addr <= 9) ml[cfg_addr - 2] = int'(cfg_wdata[11:0]);
            end
        end
    end

    function automatic logic lvl(logic raw, int bitn);
        return m_pol[bitn] ? raw : !raw;
    endfunction

    // Compare every cycle away from the active edge.
    always @(negedge clk) begin
        if (chk_en) begin
            int hs, hb, ha, vs, vb, va;
            logic r, hsr, vsr, hact, vact, vbl;
            hs = ml[0] + 1; hb = ml[1] + 1; ha = ml[2] + 1;
            vs = ml[4] + 1; vb = ml[5] + 1; va = ml[6] + 1;
            r    = (m_run != 0);
            hsr  = r && hc < hs;
            vsr  = r && vc < vs;
            hact = r && hc >= hs + hb && hc < hs + hb + ha;
            vact = r && vc >= vs + vb && vc < vs + vb + va;
            vbl  = r && vc == vs + vb + va && hc == 0;
            chk($sformatf("R2 %s hsync", ptag), hsync_o, lvl(hsr, 0));
            chk($sformatf("R4 %s vsync", ptag), vsync_o, lvl(vsr, 1));
            chk($sformatf("R3 %s de", ptag), de_o, lvl(hact && vact, 2));
            chk($sformatf("R3 %s px_x", ptag), px_x, hact ? hc - hs - hb : 0);
            chk($sformatf("R4 %s px_y", ptag), px_y, vact ? vc - vs - vb : 0);
            chk($sformatf("R7 %s vblank", ptag), vblank_o, vbl);
            chk($sformatf("R5 %s data_inv", ptag), data_inv_o, !m_pol[3]);
        end
    end

    task automatic wr(int a, int d);
        cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = 16'(d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg(int a0, int a1, int a2, int a3, int b0, int b1, int b2, int b3);
        wr(2, a0); wr(3, a1); wr(4, a2); wr(5, a3);
        wr(6, b0); wr(7, b1); wr(8, b2); wr(9, b3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 hsync", hsync_o, 0);
        chk("R1 vsync", vsync_o, 0);
        chk("R1 de", de_o, 0);
        chk("R1 vblank", vblank_o, 0);
        chk("R1 px_x", px_x, 0);
        chk("R1 px_y", px_y, 0);
        chk("R1 data_inv", data_inv_o, 0);
        rst_n = 1'b1;
        chk_en = 1;
        ptag = "R6"; idle(5);
        ptag = "R2";
        cfg(1, 1, 3, 2, 1, 0, 2, 1);
        wr(0, 1);
        idle(2 * 88 + 5);
        ptag = "R5";
        wr(1, 4'b0101); idle(100);
        wr(1, 4'b1010); idle(50);
        wr(1, 4'b1111);
        ptag = "R6";
        idle(37); wr(0, 0); idle(10); wr(0, 1); idle(30);
        ptag = "R8";
        wr(12, 5); wr(15, 0); wr(10, 16'hFFFF); idle(90);
        ptag = "R2";
        wr(0, 0); idle(2);
        cfg(0, 0, 0, 0, 0, 0, 0, 0);
        wr(0, 1); idle(60);
        wr(0, 0); idle(2);
        cfg(7, 5, 19, 3, 2, 3, 9, 4);
        wr(0, 1); idle(2 * 836 + 10);
        ptag = "R6";
        wr(0, 0); idle(10);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule